// File: doc/BRIEF.md
# Reset Cause Recorder and One-Shot Reset Controller

This block is the register-level reset manager of a small system-on-chip. It turns software writes into timed reset pulses for the whole chip, the processor core and a DMA engine. It also holds a set of level-style reset lines for individual peripherals. Alongside these controls it keeps a record of why the system was last reset: every reset source sets its own sticky flag, and software clears a flag by writing 1 to it.

The block also holds a 16-bit key register that can switch off the power-on reset circuit. The circuit is off only while the key holds one value, and most other resets put it back on.

Inputs are single-cycle reset-event pulses from the reset pin, the watchdog, the low-voltage monitor, the brown-out monitor, the processor's system-reset request, the hard-fault path, the debugger and the external power-on source. A simple word-addressed register bus reaches four words: cause flags (0), one-shot controls (1), peripheral resets (2) and power-on key (3). A `wr_allow` input gates the protected fields.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After `rst_n` is released, the cause word reads 0x001, the one-shot, peripheral and key words read 0, and every reset output is low.
- R2: In word 1, bit 0 is the chip one-shot, bit 1 the core one-shot and bit 2 the DMA one-shot. Writing 1 to a bit while `wr_allow` is high drives its output high for exactly two cycles, starting the cycle after the write. After that the bit clears itself. Writing 1 to a bit that is already active, or writing 0, has no effect.
- R3: When `wr_allow` is low, writes to word 1 and word 3 are ignored.
- R4: Cause flag bits in word 0 are: 0 power-on or chip one-shot, 1 reset pin, 2 watchdog, 3 low voltage, 4 brown-out, 5 processor system request, 7 core one-shot, 11 hard fault. An event pulse sets its flag on the next clock edge, and the flag stays set through any later reset except power-on. The debugger event sets no flag.
- R5: Writing 1 to a cause bit clears that bit, and writing 0 leaves it alone. `wr_allow` is not required for this. If an event arrives in the same cycle as the clearing write for its bit, the flag stays set.
- R6: Starting the chip one-shot sets cause bit 0, and starting the core one-shot sets cause bit 7, on the same edge that starts the pulse.
- R7: `por_off_o` is high exactly when word 3 holds 0x5AA5. Word 3 reads back its 16 stored bits, and any other written value turns power-on reset back on.
- R8: A reset-pin, watchdog, low-voltage, brown-out or debugger event, or the start of a chip one-shot, clears word 3 on the next edge.
- R9: Word 2 is plain read-write. The implemented bits are 1, 2, 3, 4, 8, 12, 16, 20, 25, 26, 28 and 30 (mask 0x5611111E), and the other bits read 0. `periph_rst_o` equals word 2.
- R10: An `ev_por` pulse returns every register to its R1 value and cancels any running one-shot. The cause word becomes 0x001, and this takes priority over all other inputs in that cycle.
- R11: `bus_rdata` shows the word selected by `bus_addr` in the same cycle, with no wait. Word 1 reads the active one-shot bits in positions 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| wr_allow | input | 1 | High when protected fields may be written |
| ev_por | input | 1 | External power-on event pulse |
| ev_pin | input | 1 | Reset-pin event pulse |
| ev_wdt | input | 1 | Watchdog event pulse |
| ev_lvr | input | 1 | Low-voltage event pulse |
| ev_bod | input | 1 | Brown-out event pulse |
| ev_sysreq | input | 1 | Processor system-reset request pulse |
| ev_hfault | input | 1 | Hard-fault reset pulse |
| ev_dbg | input | 1 | Debugger reset pulse |
| chip_rst_o | output | 1 | Chip one-shot reset |
| core_rst_o | output | 1 | Core one-shot reset |
| dma_rst_o | output | 1 | DMA one-shot reset |
| periph_rst_o | output | 32 | Per-peripheral reset levels |
| por_off_o | output | 1 | Power-on reset disabled |

## Verification
A wrong one-shot count shows up on the reset outputs within three cycles of the write: the pulse is one cycle too short or too long, or it restarts when written again while active. A corrupted cause flag or key stays hidden until word 0 or word 3 is read, or until `por_off_o` flips. For that reason the reference model compares the read word and every output on every cycle while the address moves randomly. The coincidence of an event with a clearing write, and the rearming of power-on reset by each event, are forced directly so that a priority error shows one cycle later.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int DW      = 32;
    localparam int AW      = 2;
    localparam int KEY_W   = 16;
    localparam int CAUSE_W = 12;
    localparam int OS_N    = 3;

    typedef enum logic [AW-1:0] {
        RA_CAUSE   = 2'd0,
        RA_ONESHOT = 2'd1,
        RA_PERIPH  = 2'd2,
        RA_PORKEY  = 2'd3
    } reg_addr_e;

    // cause flag positions (decoded by software)
    localparam int CF_POR    = 0;
    localparam int CF_PIN    = 1;
    localparam int CF_WDT    = 2;
    localparam int CF_LVR    = 3;
    localparam int CF_BOD    = 4;
    localparam int CF_SYSREQ = 5;
    localparam int CF_CPU    = 7;
    localparam int CF_HFAULT = 11;

    localparam logic [CAUSE_W-1:0] CAUSE_MASK  = 12'h8BF;
    localparam logic [CAUSE_W-1:0] CAUSE_RESET = 12'h001;

    // one-shot positions
    localparam int OS_CHIP = 0;
    localparam int OS_CORE = 1;
    localparam int OS_DMA  = 2;

    localparam logic [DW-1:0] PERIPH_MASK = 32'h5611_111E;
endpackage

// File: rtl/rstc_oneshot.sv
module rstc_oneshot #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic active_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } os_t;

    os_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (s_q.act) begin
            if (s_q.cnt == '0) begin
                s_d.act = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (start) begin
            s_d.act = 1'b1;
            s_d.cnt = CW'(HOLD - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.act;
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic [CAUSE_W-1:0] w1c_i,
    output logic [CAUSE_W-1:0] flags_o
);
    logic [CAUSE_W-1:0] flags_d, flags_q;

    always_comb begin
        if (clr_all) flags_d = CAUSE_RESET;
        else         flags_d = ((flags_q & ~w1c_i) | set_i) & CAUSE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= CAUSE_RESET;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int               ONESHOT_HOLD = 2,
    parameter logic [KEY_W-1:0] POR_OFF_KEY  = 16'h5AA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          wr_allow,
    input  logic          ev_por,
    input  logic          ev_pin,
    input  logic          ev_wdt,
    input  logic          ev_lvr,
    input  logic          ev_bod,
    input  logic          ev_sysreq,
    input  logic          ev_hfault,
    input  logic          ev_dbg,
    output logic          chip_rst_o,
    output logic          core_rst_o,
    output logic          dma_rst_o,
    output logic [DW-1:0] periph_rst_o,
    output logic          por_off_o
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [DW-1:0]    periph;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    reg_addr_e          sel;
    logic               wr_os, wr_cause, wr_periph, wr_key, rearm;
    logic [OS_N-1:0]    os_act, os_start;
    logic [CAUSE_W-1:0] set_v, w1c_v, cause_flags;
    logic [KEY_W-1:0]   key_val;

    assign sel       = reg_addr_e'(bus_addr);
    assign wr_os     = bus_we && (sel == RA_ONESHOT) && wr_allow;
    assign wr_key    = bus_we && (sel == RA_PORKEY) && wr_allow;
    assign wr_cause  = bus_we && (sel == RA_CAUSE);
    assign wr_periph = bus_we && (sel == RA_PERIPH);

    for (genvar i = 0; i < OS_N; i++) begin : g_os
        assign os_start[i] = wr_os && bus_wdata[i] && !os_act[i];
        rstc_oneshot #(.HOLD(ONESHOT_HOLD)) i_os (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ev_por),
            .start    (os_start[i]),
            .active_o (os_act[i])
        );
    end

    always_comb begin
        set_v            = '0;
        set_v[CF_POR]    = os_start[OS_CHIP];
        set_v[CF_PIN]    = ev_pin;
        set_v[CF_WDT]    = ev_wdt;
        set_v[CF_LVR]    = ev_lvr;
        set_v[CF_BOD]    = ev_bod;
        set_v[CF_SYSREQ] = ev_sysreq;
        set_v[CF_CPU]    = os_start[OS_CORE];
        set_v[CF_HFAULT] = ev_hfault;
        w1c_v            = wr_cause ? bus_wdata[CAUSE_W-1:0] : '0;
    end

    rstc_cause i_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (ev_por),
        .set_i   (set_v),
        .w1c_i   (w1c_v),
        .flags_o (cause_flags)
    );

    assign rearm = ev_pin | ev_wdt | ev_lvr | ev_bod | ev_dbg | os_start[OS_CHIP];

    always_comb begin
        ctl_d = ctl_q;
        if (ev_por) begin
            ctl_d = '0;
        end else begin
            if (rearm)       ctl_d.key = '0;
            else if (wr_key) ctl_d.key = bus_wdata[KEY_W-1:0];
            if (wr_periph)   ctl_d.periph = bus_wdata & PERIPH_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RA_CAUSE:   bus_rdata[CAUSE_W-1:0] = cause_flags;
            RA_ONESHOT: bus_rdata[OS_N-1:0]    = os_act;
            RA_PERIPH:  bus_rdata              = ctl_q.periph;
            RA_PORKEY:  bus_rdata[KEY_W-1:0]   = ctl_q.key;
            default:    bus_rdata              = '0;
        endcase
    end

    assign key_val      = ctl_q.key;
    assign chip_rst_o   = os_act[OS_CHIP];
    assign core_rst_o   = os_act[OS_CORE];
    assign dma_rst_o    = os_act[OS_DMA];
    assign periph_rst_o = ctl_q.periph;
    assign por_off_o    = (ctl_q.key == POR_OFF_KEY);
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk
    import rstc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [AW-1:0]      bus_addr,
    input logic               wr_allow,
    input logic               ev_por,
    input logic               ev_pin,
    input logic               ev_wdt,
    input logic               ev_lvr,
    input logic               ev_bod,
    input logic               ev_dbg,
    input logic               chip_rst_o,
    input logic               core_rst_o,
    input logic               por_off_o,
    input logic [CAUSE_W-1:0] flags,
    input logic [KEY_W-1:0]   key
);
    AST_CHIP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n || ev_por)
        $rose(chip_rst_o) |=> chip_rst_o ##1 !chip_rst_o); // R2

    AST_CORE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n || ev_por)
        $rose(core_rst_o) |=> core_rst_o ##1 !core_rst_o); // R2

    AST_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3 && !wr_allow && !ev_por &&
         !(ev_pin || ev_wdt || ev_lvr || ev_bod || ev_dbg)) |=> key == $past(key)); // R3

    AST_PIN_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pin && !ev_por) |=> flags[CF_PIN]); // R4

    AST_CHIP_SETS_POR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_o) |-> flags[CF_POR]); // R6

    AST_CORE_SETS_CPU_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_o) |-> flags[CF_CPU]); // R6

    AST_POR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pin || ev_wdt || ev_lvr || ev_bod || ev_dbg) |=> !por_off_o); // R8

    AST_POWER_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (flags == CAUSE_RESET) && !chip_rst_o && !core_rst_o); // R10
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wr_allow   (wr_allow),
    .ev_por     (ev_por),
    .ev_pin     (ev_pin),
    .ev_wdt     (ev_wdt),
    .ev_lvr     (ev_lvr),
    .ev_bod     (ev_bod),
    .ev_dbg     (ev_dbg),
    .chip_rst_o (chip_rst_o),
    .core_rst_o (core_rst_o),
    .por_off_o  (por_off_o),
    .flags      (cause_flags),
    .key        (key_val)
);

// File: tb/test_rst_cause_ctrl.sv
`timescale 1ns/1ps
module test_rst_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wr_allow = 1'b0;
    logic        ev_por = 1'b0, ev_pin = 1'b0, ev_wdt = 1'b0, ev_lvr = 1'b0;
    logic        ev_bod = 1'b0, ev_sysreq = 1'b0, ev_hfault = 1'b0, ev_dbg = 1'b0;
    logic        chip_rst_o, core_rst_o, dma_rst_o, por_off_o;
    logic [31:0] periph_rst_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rst_cause_ctrl i_rst_cause_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_allow(wr_allow),
        .ev_por(ev_por), .ev_pin(ev_pin), .ev_wdt(ev_wdt), .ev_lvr(ev_lvr),
        .ev_bod(ev_bod), .ev_sysreq(ev_sysreq), .ev_hfault(ev_hfault), .ev_dbg(ev_dbg),
        .chip_rst_o(chip_rst_o), .core_rst_o(core_rst_o), .dma_rst_o(dma_rst_o),
        .periph_rst_o(periph_rst_o), .por_off_o(por_off_o)
    );

    // behavioural reference model
    logic [11:0] m_flags = 12'h001;
    logic [15:0] m_key = '0;
    logic [31:0] m_periph = '0;
    int          m_left[3] = '{0, 0, 0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = 12'h001; m_key = '0; m_periph = '0;
            for (int i = 0; i < 3; i++) m_left[i] = 0;
        end else if (ev_por) begin
            m_flags = 12'h001; m_key = '0; m_periph = '0;
            for (int i = 0; i < 3; i++) m_left[i] = 0;
        end else begin
            bit st[3];
            logic [11:0] setv;
            for (int i = 0; i < 3; i++) begin
                st[i] = bus_we && bus_addr == 2'd1 && wr_allow && bus_wdata[i] && m_left[i] == 0;
                if (m_left[i] > 0) m_left[i] = m_left[i] - 1;
                if (st[i]) m_left[i] = 2;
            end
            setv = '0;
            if (st[0]) setv[0] = 1'b1;
            if (ev_pin) setv[1] = 1'b1;
            if (ev_wdt) setv[2] = 1'b1;
            if (ev_lvr) setv[3] = 1'b1;
            if (ev_bod) setv[4] = 1'b1;
            if (ev_sysreq) setv[5] = 1'b1;
            if (st[1]) setv[7] = 1'b1;
            if (ev_hfault) setv[11] = 1'b1;
            if (bus_we && bus_addr == 2'd0)
                m_flags = m_flags & ~(bus_wdata[11:0] & 12'h8BF);
            m_flags = m_flags | setv;
            if (ev_pin || ev_wdt || ev_lvr || ev_bod || ev_dbg || st[0]) m_key = '0;
            else if (bus_we && bus_addr == 2'd3 && wr_allow) m_key = bus_wdata[15:0];
            if (bus_we && bus_addr == 2'd2) m_periph = bus_wdata & 32'h5611_111E;
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {20'd0, m_flags};
            2'd1: return {29'd0, m_left[2] > 0, m_left[1] > 0, m_left[0] > 0};
            2'd2: return m_periph;
            default: return {16'd0, m_key};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        string rtag;
        chk("R2 chip", {31'd0, chip_rst_o}, {31'd0, m_left[0] > 0});
        chk("R2 core", {31'd0, core_rst_o}, {31'd0, m_left[1] > 0});
        chk("R2 dma",  {31'd0, dma_rst_o},  {31'd0, m_left[2] > 0});
        chk("R9 periph", periph_rst_o, m_periph);
        chk("R7 por_off", {31'd0, por_off_o}, {31'd0, m_key == 16'h5AA5});
        case (bus_addr)
            2'd0: rtag = "R4 R11 read cause";
            2'd1: rtag = "R11 read oneshot";
            2'd2: rtag = "R9 R11 read periph";
            default: rtag = "R7 R11 read key";
        endcase
        chk(rtag, bus_rdata, m_read(bus_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic allow);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; wr_allow = allow;
        tick();
        bus_we = 1'b0; wr_allow = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        peek(2'd0, d); chk("R1 cause", d, 32'h001);
        peek(2'd1, d); chk("R1 oneshot", d, 32'h0);
        peek(2'd2, d); chk("R1 periph", d, 32'h0);
        peek(2'd3, d); chk("R1 key", d, 32'h0);
        chk("R1 outputs", {28'd0, chip_rst_o, core_rst_o, dma_rst_o, por_off_o}, 32'h0);

        // R9 peripheral mask
        wr(2'd2, 32'hFFFF_FFFF, 1'b0);
        peek(2'd2, d); chk("R9 mask", d, 32'h5611_111E);
        chk("R9 out", periph_rst_o, 32'h5611_111E);
        wr(2'd2, 32'h0000_0012, 1'b0);
        chk("R9 gpio+tmr2", periph_rst_o, 32'h0000_0012);

        // R3 protection
        wr(2'd3, 32'h5AA5, 1'b0);
        peek(2'd3, d); chk("R3 key locked", d, 32'h0);
        wr(2'd1, 32'h7, 1'b0);
        chk("R3 oneshot locked", {29'd0, chip_rst_o, core_rst_o, dma_rst_o}, 32'h0);
        tick();
        chk("R3 oneshot still idle", {31'd0, chip_rst_o}, 32'h0);

        // R7 key
        wr(2'd3, 32'hFFFF_5AA5, 1'b1);
        chk("R7 off", {31'd0, por_off_o}, 32'h1);
        peek(2'd3, d); chk("R7 readback", d, 32'h5AA5);
        wr(2'd3, 32'h5AA4, 1'b1);
        chk("R7 other value", {31'd0, por_off_o}, 32'h0);

        // R8 rearm by watchdog
        wr(2'd3, 32'h5AA5, 1'b1);
        ev_wdt = 1'b1; tick(); ev_wdt = 1'b0;
        chk("R8 wdt rearm", {31'd0, por_off_o}, 32'h0);
        peek(2'd0, d); chk("R4 wdt flag", d, 32'h005);
        wr(2'd3, 32'h5AA5, 1'b1);
        ev_dbg = 1'b1; tick(); ev_dbg = 1'b0;
        chk("R8 dbg rearm", {31'd0, por_off_o}, 32'h0);
        peek(2'd0, d); chk("R4 dbg no flag", d, 32'h005);

        // R5 write-1-to-clear
        wr(2'd0, 32'h004, 1'b0);
        peek(2'd0, d); chk("R5 clear", d, 32'h001);
        wr(2'd0, 32'h000, 1'b0);
        peek(2'd0, d); chk("R5 zero write", d, 32'h001);
        ev_lvr = 1'b1;
        wr(2'd0, 32'h008, 1'b0);
        ev_lvr = 1'b0;
        peek(2'd0, d); chk("R5 set wins", d, 32'h009);
        wr(2'd0, 32'hFFF, 1'b0);
        peek(2'd0, d); chk("R5 clear all", d, 32'h000);

        // R2 / R6 chip one-shot
        wr(2'd3, 32'h5AA5, 1'b1);
        wr(2'd1, 32'h1, 1'b1);
        chk("R2 chip cycle1", {31'd0, chip_rst_o}, 32'h1);
        chk("R8 chip rearm", {31'd0, por_off_o}, 32'h0);
        peek(2'd0, d); chk("R6 por flag", d, 32'h001);
        tick();
        chk("R2 chip cycle2", {31'd0, chip_rst_o}, 32'h1);
        tick();
        chk("R2 chip cleared", {31'd0, chip_rst_o}, 32'h0);

        // core one-shot, rewrite while active ignored
        wr(2'd1, 32'h2, 1'b1);
        chk("R2 core cycle1", {31'd0, core_rst_o}, 32'h1);
        wr(2'd1, 32'h2, 1'b1);
        chk("R2 core cycle2", {31'd0, core_rst_o}, 32'h1);
        tick();
        chk("R2 core no restart", {31'd0, core_rst_o}, 32'h0);
        peek(2'd0, d); chk("R6 cpu flag", d, 32'h081);

        // R11 DMA and read of word 1
        wr(2'd1, 32'h4, 1'b1);
        peek(2'd1, d); chk("R11 oneshot read", d, 32'h4);
        tick(); tick();
        chk("R2 dma cleared", {31'd0, dma_rst_o}, 32'h0);

        // R4 other flags
        ev_sysreq = 1'b1; ev_hfault = 1'b1; ev_bod = 1'b1; ev_pin = 1'b1;
        tick();
        ev_sysreq = 1'b0; ev_hfault = 1'b0; ev_bod = 1'b0; ev_pin = 1'b0;
        peek(2'd0, d); chk("R4 flags", d, 32'h8B3);

        // R10 power-on event
        wr(2'd2, 32'h1000_0000, 1'b0);
        wr(2'd3, 32'h5AA5, 1'b1);
        wr(2'd1, 32'h1, 1'b1);
        ev_por = 1'b1; tick(); ev_por = 1'b0;
        peek(2'd0, d); chk("R10 cause", d, 32'h001);
        chk("R10 periph", periph_rst_o, 32'h0);
        chk("R10 oneshot", {31'd0, chip_rst_o}, 32'h0);
        chk("R10 key", {31'd0, por_off_o}, 32'h0);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = ($urandom_range(0, 3) == 0) ? 32'h0000_5AA5 : $urandom;
            wr_allow  = $urandom_range(0, 1) == 1;
            ev_pin    = ($urandom_range(0, 31) == 0);
            ev_wdt    = ($urandom_range(0, 31) == 0);
            ev_lvr    = ($urandom_range(0, 31) == 0);
            ev_bod    = ($urandom_range(0, 31) == 0);
            ev_sysreq = ($urandom_range(0, 31) == 0);
            ev_hfault = ($urandom_range(0, 31) == 0);
            ev_dbg    = ($urandom_range(0, 31) == 0);
            ev_por    = ($urandom_range(0, 255) == 0);
            tick();
        end
        bus_we = 1'b0; ev_pin = 1'b0; ev_wdt = 1'b0; ev_lvr = 1'b0; ev_bod = 1'b0;
        ev_sysreq = 1'b0; ev_hfault = 1'b0; ev_dbg = 1'b0; ev_por = 1'b0;
        tick();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule